// File: doc/BRIEF.md
# Thermal trip point monitor

This block watches temperature readings from a group of on-chip sensors and turns them into three kinds of consequence. A reading arrives as a signed millidegree Celsius value, a sensor index and a one-cycle valid strobe. Each sensor has two programmable trip levels. The hot level drives that sensor's throttle request to the clock-throttling hardware. The critical level either drives a dedicated shutdown line to the external power-management device or, when a separate shutdown level is programmed for that sensor, only raises an event for software.

A hot or critical trip releases only after a reading falls strictly below its level minus a shared hysteresis value (1000 millidegrees after reset). A shutdown trip does not release: the shutdown line stays high until reset. Trip events latch into a status register with write-one-to-clear bits. The level-high interrupt is the OR of the status bits that are set in an enable mask. Software can also poll the status register and a read-only register that shows the current trip state.

All configuration goes through a flat word-addressed register port with a single-cycle write strobe and a combinational read. With the default three sensors the address map is as follows. Sensor s uses addresses 4s+0 (hot level), 4s+1 (critical level), 4s+2 (dedicated shutdown level) and 4s+3 (bit 0 enables the dedicated shutdown level). Address 4N holds the hysteresis, 4N+1 the status, 4N+2 the interrupt enable and 4N+3 the live trip state.

Top module: `trip_monitor`

## Requirements
- R1: After reset the throttle requests, the shutdown line and the interrupt are low. Every hot, critical and shutdown level reads 0x0007FFFF (the largest positive value), the hysteresis reads 1000, and the dedicated levels are disabled.
- R2: A valid reading for sensor s that is greater than or equal to its hot level raises throttle_req[s] after that clock edge. No other sensor's request changes.
- R3: An active throttle request stays high for any later reading that is at or above the hot level minus the hysteresis. It drops after the first reading that is strictly below that value.
- R4: When sensor s has its dedicated level disabled, a valid reading at or above its critical level raises shutdown_o after that edge. A reading one below the critical level does not raise it.
- R5: When sensor s has its dedicated level enabled, a reading at or above the critical level but below the dedicated level sets only status bit N+s and leaves shutdown_o low. A reading at or above the dedicated level raises shutdown_o.
- R6: Once shutdown_o is high, it stays high for any reading or register write until reset.
- R7: Status bit s latches a hot trip of sensor s, bit N+s latches a critical trip and bit 2N+s latches a shutdown trip. A write to address 4N+1 clears the bits written as 1 and keeps the other bits. An event in the same cycle as a clear of its bit leaves the bit set.
- R8: irq_o is high exactly while some status bit is set whose enable bit (same position, address 4N+2) is also set.
- R9: Levels and readings are two's complement in their low 20 bits and are compared as signed values, so sub-zero levels and readings trip and release correctly.
- R10: A reading with the valid strobe low, or with a sensor index of N or above, changes no output and no status bit.
- R11: Level registers read back sign-extended to 32 bits. Address 4N+3 reads the throttle requests in bits N-1:0, the critical trip state in bits 2N-1:N and shutdown_o in bit 2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | Reading strobe, one cycle per reading |
| meas_id | input | ID_W (2) | Sensor index of the reading |
| meas_temp | input | TEMP_W (20) | Signed reading in millidegrees Celsius |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (4) | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| throttle_req | output | N_SENSORS (3) | Per-sensor hot trip throttle request |
| shutdown_o | output | 1 | Sticky shutdown trigger to the power-management device |
| irq_o | output | 1 | Level-high interrupt |

## Verification
A table of readings walks two sensors through their hot levels. One sensor has a positive level and the other a negative one. The table includes readings just below and exactly at each level, exactly at and one below the release point, and an out-of-range index. This separates an off-by-one or unsigned compare from correct signed behaviour with hysteresis. Directed sequences then compare the fallback path against the dedicated-level path, where the same critical crossing should and should not drive shutdown. Further sequences check that shutdown persists through cooling and clears, check partial and simultaneous status clears against the enable mask, and check the reset values of the register map.

// File: rtl/trip_pkg.sv
package trip_pkg;

    localparam int unsigned REG_DW = 32;

    // Word slot within one sensor's four-register group.
    typedef enum logic [1:0] {
        SLOT_HOT    = 2'd0,
        SLOT_CRIT   = 2'd1,
        SLOT_SD_THR = 2'd2,
        SLOT_SD_EN  = 2'd3
    } slot_e;

    // Word slot within the global group that follows the sensors.
    typedef enum logic [1:0] {
        GLB_HYST   = 2'd0,
        GLB_STATUS = 2'd1,
        GLB_ENABLE = 2'd2,
        GLB_LIVE   = 2'd3
    } glb_e;

endpackage

// File: rtl/trip_regs.sv
module trip_regs
    import trip_pkg::*;
#(
    parameter int unsigned N_SENSORS = 3,
    parameter int unsigned TEMP_W    = 20,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned EV_W      = 9
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [REG_DW-1:0]                   wdata,
    output logic [N_SENSORS-1:0][TEMP_W-1:0]    hot_thr,
    output logic [N_SENSORS-1:0][TEMP_W-1:0]    crit_thr,
    output logic [N_SENSORS-1:0][TEMP_W-1:0]    sd_thr,
    output logic [N_SENSORS-1:0]                sd_en,
    output logic [TEMP_W-2:0]                   hyst,
    output logic [EV_W-1:0]                     irq_en,
    output logic [EV_W-1:0]                     clr_mask
);

    localparam logic [TEMP_W-1:0] THR_RST  = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [TEMP_W-2:0] HYST_RST = (TEMP_W-1)'(1000);
    localparam int unsigned       IDX_W    = ADDR_W - 2;

    typedef struct packed {
        logic [N_SENSORS-1:0][TEMP_W-1:0] hot;
        logic [N_SENSORS-1:0][TEMP_W-1:0] crit;
        logic [N_SENSORS-1:0][TEMP_W-1:0] sd;
        logic [N_SENSORS-1:0]             sd_en;
        logic [TEMP_W-2:0]                hyst;
        logic [EV_W-1:0]                  en;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [IDX_W-1:0] grp;
    logic [1:0]       slot;
    logic             unused_wdata;

    assign grp          = addr[ADDR_W-1:2];
    assign slot         = addr[1:0];
    assign unused_wdata = ^wdata[REG_DW-1:TEMP_W];

    always_comb begin
        cfg_d    = cfg_q;
        clr_mask = '0;
        if (we) begin
            for (int s = 0; s < int'(N_SENSORS); s++) begin
                if (int'(grp) == s) begin
                    case (slot)
                        SLOT_HOT:    cfg_d.hot[s]   = wdata[TEMP_W-1:0];
                        SLOT_CRIT:   cfg_d.crit[s]  = wdata[TEMP_W-1:0];
                        SLOT_SD_THR: cfg_d.sd[s]    = wdata[TEMP_W-1:0];
                        SLOT_SD_EN:  cfg_d.sd_en[s] = wdata[0];
                        default: ;
                    endcase
                end
            end
            if (int'(grp) == int'(N_SENSORS)) begin
                case (slot)
                    GLB_HYST:   cfg_d.hyst = wdata[TEMP_W-2:0];
                    GLB_STATUS: clr_mask   = wdata[EV_W-1:0];
                    GLB_ENABLE: cfg_d.en   = wdata[EV_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.hot   <= {N_SENSORS{THR_RST}};
            cfg_q.crit  <= {N_SENSORS{THR_RST}};
            cfg_q.sd    <= {N_SENSORS{THR_RST}};
            cfg_q.sd_en <= '0;
            cfg_q.hyst  <= HYST_RST;
            cfg_q.en    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign hot_thr  = cfg_q.hot;
    assign crit_thr = cfg_q.crit;
    assign sd_thr   = cfg_q.sd;
    assign sd_en    = cfg_q.sd_en;
    assign hyst     = cfg_q.hyst;
    assign irq_en   = cfg_q.en;

endmodule

// File: rtl/trip_sensor_track.sv
module trip_sensor_track #(
    parameter int unsigned TEMP_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] hot_thr,
    input  logic [TEMP_W-1:0] crit_thr,
    input  logic [TEMP_W-1:0] sd_thr,
    input  logic              sd_en,
    input  logic [TEMP_W-2:0] hyst,
    output logic              hot_o,
    output logic              crit_o,
    output logic              hot_rise,
    output logic              crit_rise,
    output logic              sd_hit
);

    // One extra bit so that level minus hysteresis cannot wrap.
    localparam int unsigned CW = TEMP_W + 1;

    typedef struct packed {
        logic hot;
        logic crit;
    } trip_t;

    trip_t                st_d, st_q;
    logic signed [CW-1:0] t_x, hot_x, crit_x, sd_x, hys_x;
    logic signed [CW-1:0] hot_lo, crit_lo, sd_lvl;

    assign t_x     = $signed({temp[TEMP_W-1], temp});
    assign hot_x   = $signed({hot_thr[TEMP_W-1], hot_thr});
    assign crit_x  = $signed({crit_thr[TEMP_W-1], crit_thr});
    assign sd_x    = $signed({sd_thr[TEMP_W-1], sd_thr});
    assign hys_x   = $signed({2'b00, hyst});
    assign hot_lo  = hot_x - hys_x;
    assign crit_lo = crit_x - hys_x;
    assign sd_lvl  = sd_en ? sd_x : crit_x;

    always_comb begin
        st_d      = st_q;
        hot_rise  = 1'b0;
        crit_rise = 1'b0;
        sd_hit    = 1'b0;
        if (upd) begin
            if (!st_q.hot && (t_x >= hot_x)) begin
                st_d.hot = 1'b1;
                hot_rise = 1'b1;
            end else if (st_q.hot && (t_x < hot_lo)) begin
                st_d.hot = 1'b0;
            end
            if (!st_q.crit && (t_x >= crit_x)) begin
                st_d.crit = 1'b1;
                crit_rise = 1'b1;
            end else if (st_q.crit && (t_x < crit_lo)) begin
                st_d.crit = 1'b0;
            end
            sd_hit = (t_x >= sd_lvl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hot_o  = st_q.hot;
    assign crit_o = st_q.crit;

endmodule

// File: rtl/trip_status.sv
module trip_status #(
    parameter int unsigned EV_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] events,
    input  logic [EV_W-1:0] clr_mask,
    input  logic [EV_W-1:0] irq_en,
    input  logic            any_sd,
    output logic [EV_W-1:0] status,
    output logic            shutdown,
    output logic            irq
);

    typedef struct packed {
        logic [EV_W-1:0] stat;
        logic            shut;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // A new event outranks a clear of the same bit.
        st_d.stat = (st_q.stat & ~clr_mask) | events;
        st_d.shut = st_q.shut | any_sd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status   = st_q.stat;
    assign shutdown = st_q.shut;
    assign irq      = |(st_q.stat & irq_en);

endmodule

// File: rtl/trip_monitor.sv
module trip_monitor
    import trip_pkg::*;
#(
    parameter int unsigned N_SENSORS = 3,
    parameter int unsigned TEMP_W    = 20,
    parameter int unsigned ID_W      = (N_SENSORS > 1) ? $clog2(N_SENSORS) : 1,
    parameter int unsigned ADDR_W    = $clog2(4 * N_SENSORS + 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 meas_valid,
    input  logic [ID_W-1:0]      meas_id,
    input  logic [TEMP_W-1:0]    meas_temp,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic [N_SENSORS-1:0] throttle_req,
    output logic                 shutdown_o,
    output logic                 irq_o
);

    localparam int unsigned EV_W  = 3 * N_SENSORS;
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned SEXT  = REG_DW - TEMP_W;

    logic [N_SENSORS-1:0][TEMP_W-1:0] hot_thr, crit_thr, sd_thr;
    logic [N_SENSORS-1:0]             sd_en;
    logic [TEMP_W-2:0]                hyst;
    logic [EV_W-1:0]                  irq_en, clr_mask, status;
    logic [N_SENSORS-1:0]             upd, hot_st, crit_st;
    logic [N_SENSORS-1:0]             ev_hot, ev_crit, ev_sd;
    logic [IDX_W-1:0]                 grp;
    logic [1:0]                       slot;

    trip_regs #(
        .N_SENSORS (N_SENSORS),
        .TEMP_W    (TEMP_W),
        .ADDR_W    (ADDR_W),
        .EV_W      (EV_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .hot_thr  (hot_thr),
        .crit_thr (crit_thr),
        .sd_thr   (sd_thr),
        .sd_en    (sd_en),
        .hyst     (hyst),
        .irq_en   (irq_en),
        .clr_mask (clr_mask)
    );

    for (genvar g = 0; g < int'(N_SENSORS); g++) begin : g_sensor
        assign upd[g] = meas_valid && (int'(meas_id) == g);

        trip_sensor_track #(
            .TEMP_W (TEMP_W)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd       (upd[g]),
            .temp      (meas_temp),
            .hot_thr   (hot_thr[g]),
            .crit_thr  (crit_thr[g]),
            .sd_thr    (sd_thr[g]),
            .sd_en     (sd_en[g]),
            .hyst      (hyst),
            .hot_o     (hot_st[g]),
            .crit_o    (crit_st[g]),
            .hot_rise  (ev_hot[g]),
            .crit_rise (ev_crit[g]),
            .sd_hit    (ev_sd[g])
        );
    end

    trip_status #(
        .EV_W (EV_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   ({ev_sd, ev_crit, ev_hot}),
        .clr_mask (clr_mask),
        .irq_en   (irq_en),
        .any_sd   (|ev_sd),
        .status   (status),
        .shutdown (shutdown_o),
        .irq      (irq_o)
    );

    assign throttle_req = hot_st;
    assign grp          = cfg_addr[ADDR_W-1:2];
    assign slot         = cfg_addr[1:0];

    // Combinational read mux over the same map the register block decodes.
    always_comb begin
        cfg_rdata = '0;
        for (int s = 0; s < int'(N_SENSORS); s++) begin
            if (int'(grp) == s) begin
                case (slot)
                    SLOT_HOT:    cfg_rdata = {{SEXT{hot_thr[s][TEMP_W-1]}}, hot_thr[s]};
                    SLOT_CRIT:   cfg_rdata = {{SEXT{crit_thr[s][TEMP_W-1]}}, crit_thr[s]};
                    SLOT_SD_THR: cfg_rdata = {{SEXT{sd_thr[s][TEMP_W-1]}}, sd_thr[s]};
                    SLOT_SD_EN:  cfg_rdata = REG_DW'(sd_en[s]);
                    default: ;
                endcase
            end
        end
        if (int'(grp) == int'(N_SENSORS)) begin
            case (slot)
                GLB_HYST:   cfg_rdata = REG_DW'(hyst);
                GLB_STATUS: cfg_rdata = REG_DW'(status);
                GLB_ENABLE: cfg_rdata = REG_DW'(irq_en);
                GLB_LIVE:   cfg_rdata = REG_DW'({shutdown_o, crit_st, hot_st});
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trip_monitor_chk.sv
module trip_monitor_chk #(
    parameter int unsigned N_SENSORS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 meas_valid,
    input logic                 cfg_we,
    input logic [N_SENSORS-1:0] throttle_req,
    input logic                 shutdown_o,
    input logic                 irq_o
);

    // R1: outputs idle while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!shutdown_o && !irq_o && (throttle_req == '0))
                else $error("outputs active during reset");
        end
    end

    // R2: a single reading moves at most one throttle request
    p_one_sensor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> ($countones(throttle_req ^ $past(throttle_req)) <= 1));

    // R4: shutdown never rises without a reading
    p_sd_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !shutdown_o) |=> !shutdown_o);

    // R6: shutdown is sticky
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> shutdown_o);

    // R8: interrupt only moves on a reading or a register write
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !cfg_we) |=> $stable(irq_o));

    // R10: throttle state only moves on a reading
    p_no_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable(throttle_req));

endmodule

bind trip_monitor trip_monitor_chk #(
    .N_SENSORS (N_SENSORS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_valid   (meas_valid),
    .cfg_we       (cfg_we),
    .throttle_req (throttle_req),
    .shutdown_o   (shutdown_o),
    .irq_o        (irq_o)
);

// File: tb/trip_monitor_test.sv
module trip_monitor_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        meas_valid;
    logic [1:0]  meas_id;
    logic [19:0] meas_temp;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [2:0]  throttle_req;
    logic        shutdown_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    trip_monitor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid   (meas_valid),
        .meas_id      (meas_id),
        .meas_temp    (meas_temp),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .throttle_req (throttle_req),
        .shutdown_o   (shutdown_o),
        .irq_o        (irq_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Addresses for the default three sensors.
    localparam logic [3:0] A_HYST = 4'd12;
    localparam logic [3:0] A_STAT = 4'd13;
    localparam logic [3:0] A_EN   = 4'd14;
    localparam logic [3:0] A_LIVE = 4'd15;

    typedef struct packed {
        logic [1:0]  id;
        logic [31:0] temp;
        logic [2:0]  thr;
    } vec_t;

    // Sensor 0 hot = 100000, sensor 1 hot = -5000, hysteresis 1000.
    localparam vec_t VECS [9] = '{
        '{2'd0, 32'd99999,      3'b000},  // R2 one below level
        '{2'd0, 32'd100000,     3'b001},  // R2 at level
        '{2'd1, 32'hFFFFE890,   3'b001},  // R9 -6000 below -5000
        '{2'd1, 32'hFFFFEC78,   3'b011},  // R9 -5000 at level
        '{2'd0, 32'd99000,      3'b011},  // R3 exactly level-hyst holds
        '{2'd0, 32'd98999,      3'b010},  // R3 one below releases
        '{2'd3, 32'd200000,     3'b010},  // R10 index out of range
        '{2'd1, 32'hFFFFE88F,   3'b000},  // R3 R9 -6001 releases
        '{2'd2, 32'hFFFFB1E0,   3'b000}   // R9 -20000 no trip
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_meas(input logic [1:0] id, input logic [31:0] temp);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_id    = id;
        meas_temp  = temp[19:0];
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        cfg_addr = addr;
        #1;
        data = cfg_rdata;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst_n      = 1'b0;
        meas_valid = 1'b0;
        meas_id    = '0;
        meas_temp  = '0;
        cfg_we     = 1'b0;
        cfg_addr   = '0;
        cfg_wdata  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 throttle", 32'(throttle_req), 32'd0);
        check("R1 shutdown", 32'(shutdown_o), 32'd0);
        check("R1 irq", 32'(irq_o), 32'd0);
        do_read(4'd0, rd);
        check("R1 hot level", rd, 32'h0007FFFF);
        do_read(4'd5, rd);
        check("R1 crit level", rd, 32'h0007FFFF);
        do_read(A_HYST, rd);
        check("R1 hysteresis", rd, 32'd1000);
        do_read(4'd3, rd);
        check("R1 dedicated disabled", rd, 32'd0);

        do_write(4'd0, 32'd100000);
        do_write(4'd4, 32'hFFFFEC78);
        do_read(4'd4, rd);
        check("R11 negative level sign-extended", rd, 32'hFFFFEC78);

        // Table of readings
        foreach (VECS[i]) begin
            do_meas(VECS[i].id, VECS[i].temp);
            check($sformatf("R2 R3 R9 R10 vector %0d", i), 32'(throttle_req), 32'(VECS[i].thr));
        end

        // R7 status after table: hot rises of sensors 0 and 1
        do_read(A_STAT, rd);
        check("R7 status after table", rd, 32'h003);
        check("R8 irq masked", 32'(irq_o), 32'd0);

        do_write(A_EN, 32'h001);
        check("R8 irq enabled", 32'(irq_o), 32'd1);
        do_write(A_STAT, 32'h002);
        do_read(A_STAT, rd);
        check("R7 partial clear", rd, 32'h001);
        check("R8 irq still set", 32'(irq_o), 32'd1);
        do_write(A_STAT, 32'h001);
        do_read(A_STAT, rd);
        check("R7 full clear", rd, 32'h000);
        check("R8 irq cleared", 32'(irq_o), 32'd0);

        // R10 strobe low
        @(negedge clk);
        meas_id   = 2'd0;
        meas_temp = 20'd200000;
        @(negedge clk);
        check("R10 strobe low throttle", 32'(throttle_req), 32'd0);
        do_read(A_STAT, rd);
        check("R10 strobe low status", rd, 32'h000);

        // R7 event and clear of the same bit in one cycle
        @(negedge clk);
        meas_valid = 1'b1;
        meas_id    = 2'd0;
        meas_temp  = 20'd100000;
        cfg_we     = 1'b1;
        cfg_addr   = A_STAT;
        cfg_wdata  = 32'h001;
        @(negedge clk);
        meas_valid = 1'b0;
        cfg_we     = 1'b0;
        do_read(A_STAT, rd);
        check("R7 set wins over clear", rd, 32'h001);
        check("R2 throttle sensor 0", 32'(throttle_req), 32'b001);

        // R5 dedicated level on sensor 1
        do_write(A_EN, 32'h010);
        check("R8 irq disabled bit", 32'(irq_o), 32'd0);
        do_write(4'd5, 32'd50000);
        do_write(4'd6, 32'd60000);
        do_write(4'd7, 32'd1);
        do_meas(2'd1, 32'd55000);
        check("R5 crit only no shutdown", 32'(shutdown_o), 32'd0);
        check("R8 irq on crit", 32'(irq_o), 32'd1);
        do_read(A_STAT, rd);
        check("R5 R7 crit status bit", rd, 32'h013);
        do_read(A_LIVE, rd);
        check("R11 live state", rd, 32'h013);

        // R4 fallback on sensor 2
        do_write(4'd9, 32'd70000);
        do_meas(2'd2, 32'd69999);
        check("R4 one below", 32'(shutdown_o), 32'd0);
        do_meas(2'd2, 32'd70000);
        check("R4 fallback shutdown", 32'(shutdown_o), 32'd1);
        do_read(A_STAT, rd);
        check("R7 shutdown status bit", rd, 32'h133);

        // R6 sticky
        do_meas(2'd2, 32'hFFFFD8F0);
        do_write(A_STAT, 32'h1FF);
        check("R6 sticky after cooling", 32'(shutdown_o), 32'd1);
        do_read(A_STAT, rd);
        check("R7 all cleared", rd, 32'h000);
        do_read(A_LIVE, rd);
        check("R11 live shutdown bit", rd[6], 1'b1);

        apply_reset();
        @(negedge clk);
        check("R1 shutdown after reset", 32'(shutdown_o), 32'd0);
        check("R1 throttle after reset", 32'(throttle_req), 32'd0);
        do_read(4'd5, rd);
        check("R1 crit level after reset", rd, 32'h0007FFFF);

        // R5 dedicated level reached
        do_write(4'd5, 32'd50000);
        do_write(4'd6, 32'd60000);
        do_write(4'd7, 32'd1);
        do_read(4'd6, rd);
        check("R11 dedicated readback", rd, 32'd60000);
        do_meas(2'd1, 32'd59999);
        check("R5 below dedicated", 32'(shutdown_o), 32'd0);
        do_meas(2'd1, 32'd60000);
        check("R5 at dedicated", 32'(shutdown_o), 32'd1);
        do_read(A_STAT, rd);
        check("R5 R7 status crit and shutdown", rd, 32'h090);

        finish_run();
    end

endmodule